// File: doc/BRIEF.md
# Core voltage window monitor

This block watches a digitised core-supply voltage against the level chosen by a 5-bit voltage-identification code. The code is turned into a target in millivolts by arithmetic, not a stored table. Four fixed-point thresholds are derived from that target: an undervoltage set level, an undervoltage release level, an overvoltage trip level and an overvoltage release level. Each new sample is compared against them.

Three outputs come from these comparisons. Power-good stays low until the soft-start sequencer reports completion and the voltage has reached the window. Undervoltage is flagged with hysteresis and only pulls power-good low. An overvoltage sets a fault that is held until power-on reset.

While the fault is held, the block drives the PWM stage as a hysteretic shunt. It commands all outputs low while the voltage is above the trip level. It commands three-state once the voltage has fallen below the lower release level. Between the two levels the last command is kept.

Top module: `vcw_monitor`

## Requirements
- R1: The target in mV is 950 + 25*(30 - code) for codes 0 to 30, so code 0 gives 1700 mV and code 30 gives 950 mV. Code 31 means output off. While the code is 31, power-good is low and samples change neither the undervoltage nor the overvoltage state.
- R2: Power-good is a register updated on every clock. Its next value is set only when all of these hold: soft-start is done, undervoltage is clear, the fault is clear and the code is not 31.
- R3: Thresholds are floor(T*K/256), where T is the target. Undervoltage is set when a sample is strictly below the level with K=233. It clears when a sample is strictly above the level with K=248. Otherwise it holds. After reset it is set.
- R4: Undervoltage has no effect on the PWM commands. Both the clamp-low and the three-state outputs stay 0 while the fault is clear.
- R5: A sample strictly above the level with K=294 sets the fault. On that same sample the clamp-low command is set and power-good goes low.
- R6: While the fault is set, the clamp-low command is set by a sample above the K=294 level and cleared by a sample strictly below the K=289 level. Otherwise it holds. The three-state command is its complement, and both commands are 0 when the fault is clear.
- R7: The fault stays set whatever samples follow. Only reset clears it.
- R8: A change of the code takes effect on the very next sample, with no extra delay.
- R9: While reset is asserted, and after it is released, power-good is 0, undervoltage is 1, and the fault and both PWM commands are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sample_valid | input | 1 | A new voltage sample is present this cycle |
| sample | input | 11 | Sensed voltage, 1 mV per LSB |
| vid | input | 5 | Voltage-identification code |
| ss_done | input | 1 | Soft-start has completed |
| pgood | output | 1 | Power-good |
| uv_flag | output | 1 | Undervoltage indication |
| ov_fault | output | 1 | Latched overvoltage fault |
| pwm_clamp_low | output | 1 | Command all PWM outputs low |
| pwm_tristate | output | 1 | Command all PWM outputs to three-state |

## Verification
The bench places samples in the hysteresis bands and exactly on each threshold. A design that compared with the wrong sense would then toggle undervoltage or the fault one code early, and one without hysteresis would drop the clamp between the two overvoltage levels. It changes the code between two samples so that a target held back one sample would misjudge a sample that is valid only under the new code. It sends an extreme sample under code 31, and after the trip it returns the voltage into the window: power-good rising there would show a fault that is not latched. A final reset confirms that the fault does clear.

// File: rtl/vcw_pkg.sv
`timescale 1ns/1ps
package vcw_pkg;
    typedef struct packed {
        logic uv;
        logic ov;
        logic clamp;
        logic pgood;
    } vcw_state_t;

    localparam int NUM_THR = 4;
    localparam int THR_UV_SET = 0;
    localparam int THR_UV_CLR = 1;
    localparam int THR_OV_SET = 2;
    localparam int THR_OV_REL = 3;
endpackage

// File: rtl/vcw_vid_decode.sv
`timescale 1ns/1ps
module vcw_vid_decode #(
    parameter int VID_W   = 5,
    parameter int TGT_W   = 11,
    parameter int BASE_MV = 950,
    parameter int STEP_MV = 25
) (
    input  logic [VID_W-1:0] vid,
    output logic [TGT_W-1:0] target,
    output logic             off
);
    localparam int TOP_CODE = (1 << VID_W) - 2;

    always_comb begin
        int span;
        off    = (vid == {VID_W{1'b1}});
        span   = off ? 0 : (TOP_CODE - int'(vid));
        target = TGT_W'(BASE_MV + STEP_MV * span);
    end
endmodule

// File: rtl/vcw_thresholds.sv
`timescale 1ns/1ps
module vcw_thresholds
    import vcw_pkg::*;
#(
    parameter int TGT_W  = 11,
    parameter int OUT_W  = 11,
    parameter int FRAC_W = 8,
    parameter int K_UV_SET = 233,
    parameter int K_UV_CLR = 248,
    parameter int K_OV_SET = 294,
    parameter int K_OV_REL = 289
) (
    input  logic [TGT_W-1:0]              target,
    output logic [NUM_THR-1:0][OUT_W-1:0] thr
);
    localparam int PROD_W = TGT_W + FRAC_W + 2;
    localparam int KS [NUM_THR] = '{K_UV_SET, K_UV_CLR, K_OV_SET, K_OV_REL};
    localparam logic [PROD_W-1:0] OUT_MAX = PROD_W'((1 << OUT_W) - 1);

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] scaled;
        always_comb begin
            prod   = PROD_W'(target) * PROD_W'(KS[g]);
            scaled = prod >> FRAC_W;
            thr[g] = (scaled > OUT_MAX) ? OUT_W'(OUT_MAX) : OUT_W'(scaled);
        end
    end
endmodule

// File: rtl/vcw_monitor.sv
`timescale 1ns/1ps
module vcw_monitor
    import vcw_pkg::*;
#(
    parameter int VID_W   = 5,
    parameter int SENSE_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  logic [SENSE_W-1:0] sample,
    input  logic [VID_W-1:0]   vid,
    input  logic               ss_done,
    output logic               pgood,
    output logic               uv_flag,
    output logic               ov_fault,
    output logic               pwm_clamp_low,
    output logic               pwm_tristate
);
    logic [SENSE_W-1:0]              target;
    logic                            off;
    logic [NUM_THR-1:0][SENSE_W-1:0] thr;
    vcw_state_t                      state_d, state_q;

    vcw_vid_decode #(.VID_W(VID_W), .TGT_W(SENSE_W)) u_dec (
        .vid(vid), .target(target), .off(off)
    );

    vcw_thresholds #(.TGT_W(SENSE_W), .OUT_W(SENSE_W)) u_thr (
        .target(target), .thr(thr)
    );

    always_comb begin
        state_d = state_q;
        if (sample_valid && !off) begin
            if (sample < thr[THR_UV_SET])
                state_d.uv = 1'b1;
            else if (sample > thr[THR_UV_CLR])
                state_d.uv = 1'b0;
            if (sample > thr[THR_OV_SET]) begin
                state_d.ov    = 1'b1;
                state_d.clamp = 1'b1;
            end else if (state_q.ov && sample < thr[THR_OV_REL]) begin
                state_d.clamp = 1'b0;
            end
        end
        state_d.pgood = ss_done && !state_d.uv && !state_d.ov && !off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{uv: 1'b1, ov: 1'b0, clamp: 1'b0, pgood: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pgood         = state_q.pgood;
    assign uv_flag       = state_q.uv;
    assign ov_fault      = state_q.ov;
    assign pwm_clamp_low = state_q.ov & state_q.clamp;
    assign pwm_tristate  = state_q.ov & ~state_q.clamp;

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault |=> ov_fault); // R7
    AST_PG_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> !pgood); // R2
    AST_PG_LOW_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault |-> !pgood); // R5
    AST_TRIP_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_fault) |-> pwm_clamp_low); // R5
    AST_UV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !off && sample < thr[THR_UV_SET]) |=> uv_flag); // R3
    AST_SHUNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_fault && sample_valid && !off && sample < thr[THR_OV_REL]) |=> pwm_tristate); // R6
    AST_NO_CMD_WITHOUT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ov_fault && !(sample_valid && !off && sample > thr[THR_OV_SET]))
            |=> (!pwm_clamp_low && !pwm_tristate)); // R4
endmodule

// File: tb/vcw_monitor_tb.sv
`timescale 1ns/1ps
module vcw_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [10:0] sample = '0;
    logic [4:0]  vid = 5'd10;
    logic        ss_done = 1'b0;
    logic        pgood, uv_flag, ov_fault, pwm_clamp_low, pwm_tristate;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    bit m_uv = 1'b1, m_ov = 1'b0, m_cl = 1'b0;

    always #10 clk = ~clk;

    vcw_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
        .vid(vid), .ss_done(ss_done), .pgood(pgood), .uv_flag(uv_flag),
        .ov_fault(ov_fault), .pwm_clamp_low(pwm_clamp_low), .pwm_tristate(pwm_tristate)
    );

    function automatic int thr(int code, int k);
        return ((950 + 25 * (30 - code)) * k) >> 8;
    endfunction

    function automatic logic [4:0] outs();
        return {pgood, uv_flag, ov_fault, pwm_clamp_low, pwm_tristate};
    endfunction

    task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {pg,uv,ov,clamp,tri} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic send(int s, string tag);
        item_t it;
        bit off, pg;
        @(negedge clk);
        sample = 11'(s);
        sample_valid = 1'b1;
        off = (vid == 5'd31);
        if (!off) begin
            if (s < thr(int'(vid), 233)) m_uv = 1'b1;
            else if (s > thr(int'(vid), 248)) m_uv = 1'b0;
            if (s > thr(int'(vid), 294)) begin
                m_ov = 1'b1; m_cl = 1'b1;
            end else if (m_ov && s < thr(int'(vid), 289)) begin
                m_cl = 1'b0;
            end
        end
        pg = ss_done && !m_uv && !m_ov && !off;
        it.exp = {pg, m_uv, m_ov, m_ov & m_cl, m_ov & ~m_cl};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            if (sample_valid && rst_n) begin
                @(negedge clk);
                if (sb.size() > 0) begin
                    it = sb.pop_front();
                    chk(it.tag, outs(), it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        chk("R9 in reset", outs(), 5'b01000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after reset", outs(), 5'b01000);

        vid = 5'd10;
        send(1450, "R2 window reached, soft-start pending");
        ss_done = 1'b1;
        send(1450, "R2 soft-start done");
        send(1350, "R3 uv hysteresis band holds clear");
        send(thr(10, 233), "R3 sample equal to uv set level");
        send(1300, "R3 uv set below floor");
        chk("R4 uv leaves pwm commands idle", {pwm_clamp_low, pwm_tristate}, 2'b00);
        send(1350, "R3 uv hysteresis band holds set");
        send(1410, "R3 uv cleared above release");

        vid = 5'd30;
        send(1000, "R8 new code applies on next sample");
        vid = 5'd0;
        send(1650, "R1 code 0 is 1700 mV");
        vid = 5'd31;
        send(2000, "R1 code 31 off, no trip");
        vid = 5'd10;
        send(1450, "R1 leaving off code");

        send(thr(10, 294), "R5 sample equal to trip level");
        send(1666, "R5 trip sets fault and clamp");
        send(1650, "R6 band between levels keeps clamp");
        send(1630, "R6 below release gives three-state");
        send(1650, "R6 band keeps three-state");
        send(1700, "R6 above trip clamps again");
        send(1450, "R7 fault held in window");
        ss_done = 1'b0;
        send(1000, "R7 fault held at low voltage");

        @(negedge clk);
        rst_n = 1'b0;
        m_uv = 1'b1; m_ov = 1'b0; m_cl = 1'b0;
        @(negedge clk);
        chk("R7 reset clears fault", outs(), 5'b01000);
        rst_n = 1'b1;
        ss_done = 1'b1;
        send(1450, "R9 restart after reset");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule